// File: doc/BRIEF.md
# Idle Bank Forced Precharge Timer

This block watches the row state of every bank on every memory chip and closes rows that have been left open without use. A bank becomes a candidate for closing only once it has been opened by an activate and has then served at least one read or write. From that point, a per-bank down-counter measures idle time in units of a tick-enable input. When the programmed timeout elapses with no further access, the block raises a precharge request toward the command arbiter. The request names the chip and the bank, and it stays raised until the arbiter accepts it.

A programmed timeout of zero makes the block close each row straight after its access, which gives the same effect as an access with auto-precharge. A global enable switches the whole function on and off. A combinational configuration check compares the scaled timeout against the power-down idle period and raises a flag when banks could still be open at the moment power-down would begin.

The block does not schedule commands and does not check DRAM timing. The arbiter issues the actual precharge and reports it back as a precharge event.

Top module: `idle_bank_closer`

## Requirements
- R1: A bank arms only when an access (cmd_type_i = 1) reaches it while it is open, and it is opened by an activate (cmd_type_i = 0). An activate on its own never produces a request. An access to a closed bank is ignored.
- R2: An armed bank that sees no further access raises its request on the cycle after the edge that samples its fp_time_i-th tick, counted from the access.
- R3: While enable_i is low, the block creates no request and withdraws any pending request by the next cycle. Armed counters hold their value.
- R4: With enable_i high and fp_time_i = 0, an access to an open bank makes its request valid on the very next cycle.
- R5: cfg_err_o is high exactly when enable_i is high and fp_time_i * clk_ratio_i + 3 >= pd_period_i. It is combinational.
- R6: A new access to an armed bank reloads its counter to fp_time_i, which restarts the timeout.
- R7: A precharge to a bank (cmd_type_i = 2), or a close-all to its chip (cmd_type_i = 3), closes the bank, disarms it and cancels its pending request from the next cycle.
- R8: When several requests are pending, the one with the lowest chip is presented, and within that chip the lowest bank. A request stays valid until it is accepted (req_valid_o and req_ready_i both high). Acceptance removes it and disarms the bank until its next access.
- R9: Counters advance only on cycles where tick_i is high.
- R10: After reset, every bank is closed and disarmed, and no request is valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Enables forced precharge |
| fp_time_i | input | TIME_W | Idle timeout in ticks |
| pd_period_i | input | PD_W | Power-down idle period, used for the configuration check |
| clk_ratio_i | input | RATIO_W | Tick-to-power-down clock scaling factor |
| tick_i | input | 1 | Counter advance enable |
| cmd_valid_i | input | 1 | Command event valid |
| cmd_type_i | input | 2 | Command type: 0 activate, 1 access, 2 precharge bank, 3 close all banks of chip |
| cmd_chip_i | input | CHIP_W | Chip of the command |
| cmd_bank_i | input | BANK_W | Bank of the command |
| req_valid_o | output | 1 | Precharge request valid |
| req_chip_o | output | CHIP_W | Chip of the request |
| req_bank_o | output | BANK_W | Bank of the request |
| req_ready_i | input | 1 | Arbiter accepts the request |
| cfg_err_o | output | 1 | Timeout and power-down period are inconsistent |

## Verification
The bench builds the block with two chips of four banks each and a 4-bit timeout. This keeps every expiry within a few ticks, so random traffic keeps several banks armed at the same time and they often expire in the same cycle, which exercises the priority order. The 2-bit clock ratio and the 8-bit power-down period let directed values land on both sides of the configuration boundary. With only eight banks, random chip and bank picks often hit banks that are already open, armed or pending, so reloads, cancellations and accesses to closed banks occur many times in each run.

// File: rtl/idle_pkg.sv
package idle_pkg;
  typedef enum logic [1:0] {
    CMD_ACT     = 2'd0,
    CMD_ACCESS  = 2'd1,
    CMD_PRE     = 2'd2,
    CMD_PRE_ALL = 2'd3
  } cmd_e;
endpackage

// File: rtl/idle_bank_slot.sv
module idle_bank_slot
  import idle_pkg::*;
#(
  parameter int TIME_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              tick_i,
  input  logic [TIME_W-1:0] fp_time_i,
  input  logic              hit_chip_i,
  input  logic              hit_bank_i,
  input  cmd_e              cmd_type_i,
  input  logic              grant_i,
  output logic              pending_o
);
  logic              open_q, armed_q, pend_q;
  logic [TIME_W-1:0] cnt_q;
  logic              do_close, do_act, do_access;

  assign do_close  = (hit_chip_i && cmd_type_i == CMD_PRE_ALL) ||
                     (hit_bank_i && cmd_type_i == CMD_PRE);
  assign do_act    = hit_bank_i && cmd_type_i == CMD_ACT;
  assign do_access = hit_bank_i && cmd_type_i == CMD_ACCESS && open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q  <= 1'b0;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (do_close) begin
      open_q  <= 1'b0;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
    end else if (do_act) begin
      open_q  <= 1'b1;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
    end else if (do_access) begin
      cnt_q <= fp_time_i;
      if (enable_i && fp_time_i == '0) begin
        // zero timeout: close right after the access
        pend_q  <= 1'b1;
        armed_q <= 1'b0;
      end else begin
        pend_q  <= 1'b0;
        armed_q <= 1'b1;
      end
    end else begin
      if (!enable_i || grant_i) pend_q <= 1'b0;
      if (enable_i && armed_q && tick_i) begin
        if (cnt_q <= TIME_W'(1)) begin
          pend_q  <= 1'b1;
          armed_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - TIME_W'(1);
        end
      end
    end
  end

  assign pending_o = pend_q;
endmodule

// File: rtl/idle_req_pick.sv
module idle_req_pick #(
  parameter int NUM_CHIPS = 2,
  parameter int NUM_BANKS = 8,
  parameter int CHIP_W    = 1,
  parameter int BANK_W    = 3
) (
  input  logic [NUM_CHIPS*NUM_BANKS-1:0] pending_i,
  output logic                           valid_o,
  output logic [CHIP_W-1:0]              chip_o,
  output logic [BANK_W-1:0]              bank_o
);
  always_comb begin
    valid_o = |pending_i;
    chip_o  = '0;
    bank_o  = '0;
    // scan from the top so the lowest index is written last
    for (int c = NUM_CHIPS - 1; c >= 0; c--) begin
      for (int b = NUM_BANKS - 1; b >= 0; b--) begin
        if (pending_i[c*NUM_BANKS+b]) begin
          chip_o = CHIP_W'(c);
          bank_o = BANK_W'(b);
        end
      end
    end
  end
endmodule

// File: rtl/idle_cfg_check.sv
module idle_cfg_check #(
  parameter int TIME_W  = 8,
  parameter int PD_W    = 12,
  parameter int RATIO_W = 3
) (
  input  logic               enable_i,
  input  logic [TIME_W-1:0]  fp_time_i,
  input  logic [RATIO_W-1:0] clk_ratio_i,
  input  logic [PD_W-1:0]    pd_period_i,
  output logic               cfg_err_o
);
  localparam int PW = TIME_W + RATIO_W + 1;
  localparam int CW = (PW > PD_W) ? PW : PD_W;

  logic [PW-1:0] scaled;
  assign scaled    = PW'(fp_time_i) * PW'(clk_ratio_i) + PW'(3);
  assign cfg_err_o = enable_i && (CW'(scaled) >= CW'(pd_period_i));
endmodule

// File: rtl/idle_bank_closer.sv
module idle_bank_closer
  import idle_pkg::*;
#(
  parameter int NUM_CHIPS = 2,
  parameter int NUM_BANKS = 8,
  parameter int TIME_W    = 8,
  parameter int PD_W      = 12,
  parameter int RATIO_W   = 3,
  localparam int CHIP_W   = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic [TIME_W-1:0]  fp_time_i,
  input  logic [PD_W-1:0]    pd_period_i,
  input  logic [RATIO_W-1:0] clk_ratio_i,
  input  logic               tick_i,
  input  logic               cmd_valid_i,
  input  logic [1:0]         cmd_type_i,
  input  logic [CHIP_W-1:0]  cmd_chip_i,
  input  logic [BANK_W-1:0]  cmd_bank_i,
  output logic               req_valid_o,
  output logic [CHIP_W-1:0]  req_chip_o,
  output logic [BANK_W-1:0]  req_bank_o,
  input  logic               req_ready_i,
  output logic               cfg_err_o
);
  localparam int NUM_SLOTS = NUM_CHIPS * NUM_BANKS;

  cmd_e                 cmd_type;
  logic [NUM_SLOTS-1:0] pending;
  logic                 accept;

  assign cmd_type = cmd_e'(cmd_type_i);
  assign accept   = req_valid_o && req_ready_i;

  for (genvar c = 0; c < NUM_CHIPS; c++) begin : g_chip
    logic hit_chip;
    assign hit_chip = cmd_valid_i && (cmd_chip_i == CHIP_W'(c));
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic hit_bank, grant;
      assign hit_bank = hit_chip && (cmd_bank_i == BANK_W'(b));
      assign grant    = accept && req_chip_o == CHIP_W'(c) && req_bank_o == BANK_W'(b);
      idle_bank_slot #(.TIME_W(TIME_W)) u_slot (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .enable_i   (enable_i),
        .tick_i     (tick_i),
        .fp_time_i  (fp_time_i),
        .hit_chip_i (hit_chip),
        .hit_bank_i (hit_bank),
        .cmd_type_i (cmd_type),
        .grant_i    (grant),
        .pending_o  (pending[c*NUM_BANKS+b])
      );
    end
  end

  idle_req_pick #(
    .NUM_CHIPS(NUM_CHIPS), .NUM_BANKS(NUM_BANKS), .CHIP_W(CHIP_W), .BANK_W(BANK_W)
  ) u_pick (
    .pending_i (pending),
    .valid_o   (req_valid_o),
    .chip_o    (req_chip_o),
    .bank_o    (req_bank_o)
  );

  idle_cfg_check #(.TIME_W(TIME_W), .PD_W(PD_W), .RATIO_W(RATIO_W)) u_cfg (
    .enable_i    (enable_i),
    .fp_time_i   (fp_time_i),
    .clk_ratio_i (clk_ratio_i),
    .pd_period_i (pd_period_i),
    .cfg_err_o   (cfg_err_o)
  );
endmodule

// File: rtl/idle_bank_closer_chk.sv
module idle_bank_closer_chk
  import idle_pkg::*;
#(
  parameter int NUM_CHIPS = 2,
  parameter int NUM_BANKS = 8,
  parameter int CHIP_W    = 1,
  parameter int BANK_W    = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              enable_i,
  input logic              tick_i,
  input logic              cmd_valid_i,
  input logic [1:0]        cmd_type_i,
  input logic [CHIP_W-1:0] cmd_chip_i,
  input logic [BANK_W-1:0] cmd_bank_i,
  input logic              req_valid_o,
  input logic [CHIP_W-1:0] req_chip_o,
  input logic [BANK_W-1:0] req_bank_o,
  input logic              req_ready_i
);
  assert_disabled_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !req_valid_o);

  assert_no_spurious_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_valid_o && !tick_i && !cmd_valid_i) |=> !req_valid_o);

  assert_pre_cancels_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_type_i == CMD_PRE) |=>
      !(req_valid_o && req_chip_o == $past(cmd_chip_i) && req_bank_o == $past(cmd_bank_i)));

  assert_held_until_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i && enable_i && !cmd_valid_i) |=> req_valid_o);

  assert_ack_retires_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_ready_i && !cmd_valid_i && !tick_i) |=>
      !(req_valid_o && req_chip_o == $past(req_chip_o) && req_bank_o == $past(req_bank_o)));
endmodule

bind idle_bank_closer idle_bank_closer_chk #(
  .NUM_CHIPS(NUM_CHIPS), .NUM_BANKS(NUM_BANKS), .CHIP_W(CHIP_W), .BANK_W(BANK_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .enable_i    (enable_i),
  .tick_i      (tick_i),
  .cmd_valid_i (cmd_valid_i),
  .cmd_type_i  (cmd_type_i),
  .cmd_chip_i  (cmd_chip_i),
  .cmd_bank_i  (cmd_bank_i),
  .req_valid_o (req_valid_o),
  .req_chip_o  (req_chip_o),
  .req_bank_o  (req_bank_o),
  .req_ready_i (req_ready_i)
);

// File: tb/idle_bank_closer_bench.sv
`timescale 1ns/100ps
module idle_bank_closer_bench;
  localparam int NC = 2, NB = 4, TW = 4, PW = 8, RW = 2;
  localparam int NS = NC * NB;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          en = 1'b0, tick = 1'b0, cv = 1'b0, rdy = 1'b0;
  logic [TW-1:0] fp = '0;
  logic [PW-1:0] pd = '0;
  logic [RW-1:0] ratio = '0;
  logic [1:0]    ct = '0;
  logic          cc = '0;
  logic [1:0]    cb = '0;
  logic          rv, rc, err;
  logic [1:0]    rb;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference state
  int m_open[NS], m_armed[NS], m_pend[NS], m_cnt[NS];

  always #2.5 clk = ~clk;

  idle_bank_closer #(.NUM_CHIPS(NC), .NUM_BANKS(NB), .TIME_W(TW), .PD_W(PW), .RATIO_W(RW))
  u_idle_bank_closer (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .fp_time_i(fp), .pd_period_i(pd),
    .clk_ratio_i(ratio), .tick_i(tick), .cmd_valid_i(cv), .cmd_type_i(ct),
    .cmd_chip_i(cc), .cmd_bank_i(cb), .req_valid_o(rv), .req_chip_o(rc),
    .req_bank_o(rb), .req_ready_i(rdy), .cfg_err_o(err)
  );

  function automatic int m_sel();
    for (int i = 0; i < NS; i++) if (m_pend[i] != 0) return i;
    return -1;
  endfunction

  function automatic bit exp_err(int e, int f, int r, int p);
    return (e != 0) && (f * r + 3 >= p);
  endfunction

  task automatic m_update();
    int g = (m_sel() >= 0 && rdy) ? m_sel() : -1;
    for (int i = 0; i < NS; i++) begin
      bit hc = cv && (int'(cc) == i / NB);
      bit hb = hc && (int'(cb) == i % NB);
      if ((hc && ct == 2'd3) || (hb && ct == 2'd2)) begin
        m_open[i] = 0; m_armed[i] = 0; m_pend[i] = 0;
      end else if (hb && ct == 2'd0) begin
        m_open[i] = 1; m_armed[i] = 0; m_pend[i] = 0;
      end else if (hb && ct == 2'd1 && m_open[i] != 0) begin
        m_cnt[i] = int'(fp);
        if (en && fp == 0) begin m_pend[i] = 1; m_armed[i] = 0; end
        else begin m_pend[i] = 0; m_armed[i] = 1; end
      end else begin
        if (!en || g == i) m_pend[i] = 0;
        if (en && m_armed[i] != 0 && tick) begin
          if (m_cnt[i] <= 1) begin m_pend[i] = 1; m_armed[i] = 0; end
          else m_cnt[i]--;
        end
      end
    end
  endtask

  task automatic check_out(string tag);
    int s = m_sel();
    bit ev = (s >= 0);
    int ec = ev ? s / NB : 0;
    int eb = ev ? s % NB : 0;
    checks++;
    if (rv !== ev || (ev && (int'(rc) != ec || int'(rb) != eb))) begin
      failures++;
      $display("FAIL %s req: got v=%0b c=%0d b=%0d exp v=%0b c=%0d b=%0d",
               tag, rv, rc, rb, ev, ec, eb);
    end
  endtask

  // drive at negedge, clock, update model, compare at next negedge
  task automatic step(string tag, bit v, int t, int c, int b, bit tk, bit r);
    cv = v; ct = 2'(t); cc = 1'(c); cb = 2'(b); tick = tk; rdy = r;
    @(posedge clk);
    m_update();
    @(negedge clk);
    check_out(tag);
  endtask

  task automatic idle(string tag, int n, bit tk, bit r);
    for (int k = 0; k < n; k++) step(tag, 0, 0, 0, 0, tk, r);
  endtask

  task automatic cfg_check(int f, int r, int p);
    fp = TW'(f); ratio = RW'(r); pd = PW'(p);
    #1;
    checks++;
    if (err !== exp_err(int'(en), f, r, p)) begin
      failures++;
      $display("FAIL R5 cfg_err f=%0d r=%0d p=%0d: got %0b exp %0b",
               f, r, p, err, exp_err(int'(en), f, r, p));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NS; i++) begin m_open[i] = 0; m_armed[i] = 0; m_pend[i] = 0; m_cnt[i] = 0; end
    repeat (3) @(negedge clk);
    check_out("R10");
    rst_n = 1'b1;
    @(negedge clk);
    check_out("R10");

    en = 1; fp = 4'd3; ratio = 2'd1; pd = 8'd20;
    // R1: activate only, no access
    step("R1", 1, 0, 0, 1, 1, 0);
    idle("R1", 8, 1, 0);
    // R1: access to a closed bank
    step("R1", 1, 1, 1, 3, 1, 0);
    idle("R1", 6, 1, 0);
    // R2: access then expiry after 3 ticks, held until ack (R8)
    step("R2", 1, 1, 0, 1, 0, 0);
    idle("R2", 5, 1, 0);
    idle("R8", 3, 0, 0);
    step("R8", 0, 0, 0, 0, 0, 1);
    idle("R8", 4, 1, 0);
    // R9: no tick, no progress
    step("R9", 1, 0, 1, 2, 0, 0);
    step("R9", 1, 1, 1, 2, 0, 0);
    idle("R9", 6, 0, 0);
    idle("R9", 4, 1, 1);
    // R6: reload
    step("R6", 1, 1, 0, 1, 1, 0);
    idle("R6", 2, 1, 0);
    step("R6", 1, 1, 0, 1, 1, 0);
    idle("R6", 2, 1, 0);
    idle("R6", 2, 1, 0);
    // R7: precharge cancels pending and armed
    step("R7", 1, 2, 0, 1, 1, 0);
    idle("R7", 4, 1, 0);
    step("R7", 1, 0, 1, 0, 1, 0);
    step("R7", 1, 1, 1, 0, 1, 0);
    step("R7", 1, 3, 1, 0, 1, 0);
    idle("R7", 5, 1, 0);
    // R4: zero timeout
    fp = 4'd0;
    step("R4", 1, 0, 0, 2, 1, 0);
    step("R4", 1, 1, 0, 2, 0, 0);
    step("R4", 0, 0, 0, 0, 0, 1);
    idle("R4", 2, 1, 0);
    // R8: simultaneous expiries, priority order
    fp = 4'd2;
    step("R8", 1, 0, 1, 1, 0, 0);
    step("R8", 1, 0, 0, 3, 0, 0);
    step("R8", 1, 0, 1, 0, 0, 0);
    step("R8", 1, 1, 1, 1, 0, 0);
    step("R8", 1, 1, 0, 3, 0, 0);
    step("R8", 1, 1, 1, 0, 0, 0);
    idle("R8", 3, 1, 0);
    idle("R8", 4, 0, 1);
    // R3: enable low withdraws and blocks
    step("R3", 1, 1, 0, 3, 0, 0);
    step("R3", 1, 1, 0, 2, 1, 0);
    step("R3", 0, 0, 0, 0, 1, 0);
    step("R3", 0, 0, 0, 0, 1, 0);
    en = 0;
    idle("R3", 5, 1, 0);
    en = 1;
    idle("R3", 4, 1, 1);
    // R5: configuration check
    cfg_check(3, 1, 7);
    cfg_check(4, 1, 7);
    cfg_check(5, 2, 14);
    cfg_check(5, 2, 13);
    cfg_check(15, 3, 255);
    cfg_check(0, 0, 3);
    en = 0; cfg_check(15, 3, 4); en = 1;
    fp = 4'd3;
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int sel = int'($urandom_range(0, 9));
      if (n % 500 == 0) fp = TW'($urandom_range(0, 5));
      en = ($urandom_range(0, 19) != 0);
      step("RND", sel < 6, (sel < 2) ? 0 : (sel < 4) ? 1 : ($urandom_range(0, 3) == 0) ? 3 : 2,
           int'($urandom_range(0, NC - 1)), int'($urandom_range(0, NB - 1)),
           $urandom_range(0, 2) != 0, $urandom_range(0, 2) == 0);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule